// File: doc/BRIEF.md
# LFSR Random and CRC16 Engine

This block keeps a single 16-bit linear feedback shift register behind a small byte-wide register bus. The same register serves three jobs: it makes pseudo-random bytes, it computes a CRC16 over bytes written to it, and it can be loaded with a seed. Each job moves the register by a different number of serial steps in one clock: 13 for a random draw, 8 for a CRC byte, and 1 for a single step. The feedback polynomial is x^16 + x^15 + x^2 + 1.

Software loads a seed by writing the low data address twice. It then streams CRC bytes into the high data address, one per clock if needed, or draws random bytes by reading the low address. A 2-bit mode field at the control address picks how the register moves. The mode field is the state of a four-state machine:

- MODE_READ (00): a read of the low address draws a new random byte.
- MODE_STEP (01): the register takes one serial step on the next free cycle, then the machine goes back to MODE_READ.
- MODE_RSVD (10) and MODE_OFF (11): the register stands still.

The machine has three transitions:

- CTL_WRITE: a control write moves the machine to the written mode.
- STEP_DONE: MODE_STEP moves to MODE_READ once a cycle passes with no bus write.
- HOLD: every other case keeps the current mode.

Top module: `rng_crc_engine`

## Requirements
- R1: After reset the register holds 0x0000, the mode is 00 and `bus_rdata` is 0x00.
- R2: A write to address 0 moves the old low byte into the high byte and loads the written byte into the low byte.
- R3: A write to address 1 runs 8 serial steps in one clock, taking the written byte MSB first. Back-to-back writes on consecutive cycles are each absorbed.
- R4: Seeded with 0xFFFF and fed 0x03, 0x41, 0x42, 0x43 through address 1, the register reads back as 0xB4BC.
- R5: A read of address 0 returns the register's low byte before any change, one cycle later on `bus_rdata`. In mode 00 the same read then advances the register by 13 serial steps with a zero data bit.
- R6: A read of address 1 returns the high byte one cycle later and never moves the register.
- R7: Writing 01 to address 2 makes the register take exactly one serial step on the first later cycle with no bus write. The mode then reads back as 00.
- R8: In modes 11 and 10, reads leave the register unchanged. A read of address 2 returns the mode in bits 1:0 with zeros above.
- R9: When a write and a read come in the same cycle, the write is applied and the read does not advance the register. The read still returns the byte held before the write.
- R10: One serial step computes feedback = data bit XOR bit 15. It shifts the register left by one and XORs the feedback into bits 0, 2 and 15.
- R11: Writes to address 3 change neither the register nor the mode, and reads of address 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 2 | 0 low data, 1 high data/CRC, 2 mode, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe |

## Verification
The assertions assume that each strobe lasts a single cycle. They also assume that the address and write data are stable at the clock edge that samples the strobe, and that mode 01 lasts only until the next cycle free of writes. The bench drives every access from the falling edge for exactly one cycle and holds both strobes low between accesses. It does write and read in the same cycle, on purpose, to cover R9. It also places a data write straight after a single-step request, so the deferred step is exercised without breaking those assumptions.

// File: rtl/rng_pkg.sv
package rng_pkg;

    typedef enum logic [1:0] {
        MODE_READ = 2'b00,
        MODE_STEP = 2'b01,
        MODE_RSVD = 2'b10,
        MODE_OFF  = 2'b11
    } rng_mode_e;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_SEED,
        OP_CRC,
        OP_STEP,
        OP_DRAW
    } rng_op_e;

    localparam logic [1:0] ADDR_LO  = 2'd0;
    localparam logic [1:0] ADDR_HI  = 2'd1;
    localparam logic [1:0] ADDR_CTL = 2'd2;

endpackage

// File: rtl/rng_lfsr_unroll.sv
module rng_lfsr_unroll #(
    parameter int unsigned           W     = 16,
    parameter logic [W-1:0]          POLY  = 16'h8005,
    parameter int unsigned           STEPS = 8
) (
    input  logic [W-1:0]     seed_i,
    input  logic [STEPS-1:0] din_i,
    output logic [W-1:0]     next_o
);

    logic [W-1:0] stage [STEPS+1];

    assign stage[0] = seed_i;

    // din_i is consumed from its top bit down, one bit per stage
    for (genvar k = 0; k < STEPS; k++) begin : g_stage
        logic fb;
        assign fb           = din_i[STEPS-1-k] ^ stage[k][W-1];
        assign stage[k+1]   = {stage[k][W-2:0], 1'b0} ^ ({W{fb}} & POLY);
    end

    assign next_o = stage[STEPS];

endmodule

// File: rtl/rng_ctrl_fsm.sv
module rng_ctrl_fsm
    import rng_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       any_wr_i,
    input  logic       ctl_wr_i,
    input  logic [1:0] ctl_val_i,
    output rng_mode_e  mode_o,
    output logic       step_fire_o,
    output logic       draw_en_o
);

    rng_mode_e mode_q, mode_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_READ;
        end else begin
            mode_q <= mode_d;
        end
    end

    // transitions: CTL_WRITE, STEP_DONE, HOLD
    always_comb begin
        mode_d = mode_q;
        if (ctl_wr_i) begin
            mode_d = rng_mode_e'(ctl_val_i);
        end else begin
            unique case (mode_q)
                MODE_READ: mode_d = MODE_READ;
                MODE_STEP: mode_d = any_wr_i ? MODE_STEP : MODE_READ;
                MODE_RSVD: mode_d = MODE_RSVD;
                MODE_OFF:  mode_d = MODE_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        step_fire_o = 1'b0;
        draw_en_o   = 1'b0;
        unique case (mode_q)
            MODE_READ: draw_en_o   = 1'b1;
            MODE_STEP: step_fire_o = !any_wr_i;
            MODE_RSVD: ;
            MODE_OFF:  ;
        endcase
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/rng_crc_engine.sv
module rng_crc_engine
    import rng_pkg::*;
#(
    parameter int unsigned             BYTE_W     = 8,
    parameter logic [2*BYTE_W-1:0]     POLY       = 16'h8005,
    parameter int unsigned             DRAW_STEPS = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata
);

    localparam int unsigned STATE_W = 2 * BYTE_W;

    logic [STATE_W-1:0] lfsr_q, lfsr_d;
    logic [STATE_W-1:0] crc_next, draw_next, one_next;
    rng_mode_e          mode_q;
    logic               step_fire, draw_en;
    rng_op_e            op;

    rng_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_wr_i    (bus_wr),
        .ctl_wr_i    (bus_wr && (bus_addr == ADDR_CTL)),
        .ctl_val_i   (bus_wdata[1:0]),
        .mode_o      (mode_q),
        .step_fire_o (step_fire),
        .draw_en_o   (draw_en)
    );

    rng_lfsr_unroll #(.W(STATE_W), .POLY(POLY), .STEPS(BYTE_W)) u_crc (
        .seed_i (lfsr_q),
        .din_i  (bus_wdata),
        .next_o (crc_next)
    );

    rng_lfsr_unroll #(.W(STATE_W), .POLY(POLY), .STEPS(DRAW_STEPS)) u_draw (
        .seed_i (lfsr_q),
        .din_i  ({DRAW_STEPS{1'b0}}),
        .next_o (draw_next)
    );

    rng_lfsr_unroll #(.W(STATE_W), .POLY(POLY), .STEPS(1)) u_one (
        .seed_i (lfsr_q),
        .din_i  (1'b0),
        .next_o (one_next)
    );

    // operation select: writes win over the step and over read draws
    always_comb begin
        op = OP_HOLD;
        if (bus_wr) begin
            if (bus_addr == ADDR_LO)      op = OP_SEED;
            else if (bus_addr == ADDR_HI) op = OP_CRC;
        end else if (step_fire) begin
            op = OP_STEP;
        end else if (bus_rd && (bus_addr == ADDR_LO) && draw_en) begin
            op = OP_DRAW;
        end
    end

    always_comb begin
        unique case (op)
            OP_SEED: lfsr_d = {lfsr_q[BYTE_W-1:0], bus_wdata};
            OP_CRC:  lfsr_d = crc_next;
            OP_STEP: lfsr_d = one_next;
            OP_DRAW: lfsr_d = draw_next;
            default: lfsr_d = lfsr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= '0;
        end else begin
            lfsr_q <= lfsr_d;
        end
    end

    // read data captures the pre-update state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (bus_addr)
                ADDR_LO:  bus_rdata <= lfsr_q[BYTE_W-1:0];
                ADDR_HI:  bus_rdata <= lfsr_q[STATE_W-1:BYTE_W];
                ADDR_CTL: bus_rdata <= {{(BYTE_W-2){1'b0}}, mode_q};
                default:  bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/rng_crc_engine_chk.sv
module rng_crc_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [1:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [15:0] state,
    input logic [1:0]  mode
);

    // R2
    seed_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> (state == {$past(state[7:0]), $past(bus_wdata)}));

    // R5
    low_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0) |=> (bus_rdata == $past(state[7:0])));

    // R6
    high_read_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == 2'd1 && mode != 2'b01) |=> $stable(state));

    // R7
    step_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !bus_wr) |=> (mode == 2'b00));

    // R8
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && !bus_wr) |=> $stable(state));

    // R11
    addr3_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3) |=> ($stable(state) && $stable(mode)));

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rd && bus_addr == 2'd0) |=> (state[7:0] == $past(bus_wdata)));

endmodule

bind rng_crc_engine rng_crc_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .state     (lfsr_q),
    .mode      (mode_q)
);

// File: tb/tb_rng_crc_engine.sv
module tb_rng_crc_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [15:0] ref_state = 16'h0000;
    logic [1:0]  ref_mode  = 2'b00;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_seen = 1'b0;

    always #5 clk = ~clk;

    rng_crc_engine dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // bit-serial reference step (R10)
    function automatic logic [15:0] ref_step(input logic [15:0] s, input logic b);
        logic [15:0] r;
        logic        fb;
        fb = b ^ s[15];
        r  = {s[14:0], 1'b0};
        if (fb) begin
            r[0]  = ~r[0];
            r[2]  = ~r[2];
            r[15] = ~r[15];
        end
        return r;
    endfunction

    // driver: one bus cycle, model updated, expected read pushed
    task automatic bus_cycle(input logic wr, input logic rd, input logic [1:0] addr,
                             input logic [7:0] wdata, input string tag,
                             input bit lit, input logic [7:0] lit_val);
        logic [7:0] rexp;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = addr; bus_wdata = wdata;
        case (addr)
            2'd0:    rexp = ref_state[7:0];
            2'd1:    rexp = ref_state[15:8];
            2'd2:    rexp = {6'b0, ref_mode};
            default: rexp = 8'h00;
        endcase
        if (rd) begin
            exp_q.push_back(lit ? lit_val : rexp);
            tag_q.push_back(tag);
        end
        if (wr) begin
            if (addr == 2'd0) ref_state = {ref_state[7:0], wdata};
            else if (addr == 2'd1)
                for (int i = 7; i >= 0; i--) ref_state = ref_step(ref_state, wdata[i]);
            else if (addr == 2'd2) ref_mode = wdata[1:0];
        end else if (ref_mode == 2'b01) begin
            ref_state = ref_step(ref_state, 1'b0);
            ref_mode  = 2'b00;
        end else if (rd && addr == 2'd0 && ref_mode == 2'b00) begin
            for (int i = 0; i < 13; i++) ref_state = ref_step(ref_state, 1'b0);
        end
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        bus_cycle(1'b1, 1'b0, a, d, "", 1'b0, 8'h00);
    endtask
    task automatic do_rd(input logic [1:0] a, input string tag);
        bus_cycle(1'b0, 1'b1, a, 8'h00, tag, 1'b0, 8'h00);
    endtask
    task automatic do_rd_lit(input logic [1:0] a, input logic [7:0] v, input string tag);
        bus_cycle(1'b0, 1'b1, a, 8'h00, tag, 1'b1, v);
    endtask
    task automatic do_idle();
        bus_cycle(1'b0, 1'b0, 2'd0, 8'h00, "", 1'b0, 8'h00);
    endtask

    // monitor: pops one expected byte per read response
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen && rst_n) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            tests++;
            if (bus_rdata !== e) begin
                fails++;
                $display("FAIL %s: bus_rdata actual %02h expected %02h", t, bus_rdata, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (bus_rdata !== 8'h00) begin
            fails++;
            $display("FAIL R1: reset rdata actual %02h expected 00", bus_rdata);
        end
        rst_n = 1'b1;

        // R1 reset state
        do_rd_lit(2'd2, 8'h00, "R1 mode");
        do_rd_lit(2'd1, 8'h00, "R1 high");
        do_rd_lit(2'd0, 8'h00, "R1 low");

        // R2 seeding, read back in mode 11
        do_wr(2'd0, 8'h12);
        do_wr(2'd0, 8'h34);
        do_wr(2'd2, 8'h03);
        do_rd_lit(2'd1, 8'h12, "R2 high");
        do_rd_lit(2'd0, 8'h34, "R2 low");

        // R8 off and reserved modes
        do_rd_lit(2'd0, 8'h34, "R8 off low");
        do_rd_lit(2'd2, 8'h03, "R8 mode 11");
        do_wr(2'd2, 8'h02);
        do_rd(2'd0, "R8 rsvd low");
        do_rd(2'd0, "R8 rsvd low again");
        do_rd_lit(2'd2, 8'h02, "R8 mode 10");

        // R4 CRC vector, back to back bytes
        do_wr(2'd0, 8'hFF);
        do_wr(2'd0, 8'hFF);
        do_wr(2'd1, 8'h03);
        do_wr(2'd1, 8'h41);
        do_wr(2'd1, 8'h42);
        do_wr(2'd1, 8'h43);
        do_rd_lit(2'd1, 8'hB4, "R4 high");
        do_rd_lit(2'd0, 8'hBC, "R4 low");

        // R7 single step, then mode clears
        do_wr(2'd2, 8'h01);
        do_idle();
        do_rd_lit(2'd2, 8'h00, "R7 mode cleared");
        do_wr(2'd2, 8'h03);
        do_rd(2'd1, "R7 high after step");
        do_rd(2'd0, "R7 low after step");
        // step deferred behind a data write
        do_wr(2'd2, 8'h01);
        do_wr(2'd0, 8'h5A);
        do_rd_lit(2'd2, 8'h01, "R7 step pending");
        do_rd(2'd0, "R7 low after deferred step");

        // R3 / R10 random seeds and streamed bytes
        do_wr(2'd2, 8'h03);
        for (int n = 0; n < 20; n++) begin
            do_wr(2'd0, 8'($urandom));
            do_wr(2'd0, 8'($urandom));
            for (int b = 0; b < 4; b++) do_wr(2'd1, 8'($urandom));
            do_rd(2'd1, "R3 R10 high");
            do_rd(2'd0, "R3 R10 low");
        end

        // R5 / R6 draws in mode 00
        for (int n = 0; n < 10; n++) begin
            do_wr(2'd2, 8'h00);
            do_wr(2'd0, 8'($urandom));
            do_wr(2'd0, 8'($urandom));
            for (int k = 0; k < 6; k++) do_rd(2'd0, "R5 draw");
            do_rd(2'd1, "R6 high");
            do_rd(2'd1, "R6 high repeat");
        end

        // R9 write and read together
        do_wr(2'd0, 8'hC3);
        bus_cycle(1'b1, 1'b1, 2'd0, 8'h77, "R9 pre-write byte", 1'b0, 8'h00);
        do_wr(2'd2, 8'h03);
        do_rd_lit(2'd0, 8'h77, "R9 write applied");
        do_rd_lit(2'd1, 8'hC3, "R9 no advance");

        // R11 unused address
        do_wr(2'd3, 8'hFF);
        do_rd_lit(2'd3, 8'h00, "R11 read zero");
        do_rd_lit(2'd2, 8'h03, "R11 mode kept");
        do_rd_lit(2'd0, 8'h77, "R11 state kept");

        repeat (3) do_idle();
        finish_run();
    end

endmodule